// File: doc/BRIEF.md
# All-Digital Phase-Locked Loop

This block tracks a single-bit reference input using only the system clock. It synchronises the reference and takes single-cycle pulses on its rising edges. It compares those pulses with feedback pulses taken from a divided copy of an internal accumulator oscillator. It turns the comparison into a signed phase error and runs that error through a proportional-integral filter. The filter output steers the oscillator's per-cycle phase step.

The comparison has two modes. The first is a sign-only mode that reports which edge came first. The second is a counting mode that reports the difference between two free-running cycle counters. A lock flag is raised only after the error has stayed inside a programmable window for a programmable number of cycles.

The block carries no data stream. Every output is a status word refreshed on every clock, with no valid/ready handshake and therefore no back-pressure. A consumer samples the outputs whenever it needs them. The gains, threshold, qualification time, divider ratio and detector mode are plain control inputs. They may change at any clock.

Top module: `adpll_core`

## Requirements
- R1: With `pd_bang` = 1, `phase_err` only takes the values -1, 0 and +1. It becomes +1 after a reference edge is followed by a feedback edge, and -1 after a feedback edge is followed by a reference edge. It holds that decision until the next one.
- R2: With `pd_bang` = 0, two counters of EW-1 bits each clear on their own edge pulse and otherwise count up, saturating at 2^(EW-1)-1. `phase_err` is the reference count minus the feedback count, delayed by one register.
- R3: Each clock, `filt_word` becomes clamp(NOM + ((kp*e) >>> FRAC) + I). The integral I then gains (ki*e) >>> FRAC. Here e is the `phase_err` value held before the edge, and `>>>` is an arithmetic shift that rounds toward minus infinity.
- R4: The integral saturates at the signed limits of IW bits (-2^(IW-1) and 2^(IW-1)-1) instead of wrapping.
- R5: `filt_word` is clamped to the range 1 to N/2.
- R6: Each clock the oscillator adds `filt_word` to its accumulator. When the sum reaches N or more, N is subtracted, `dco_clk` toggles and `dco_tick` pulses for that one cycle. Ticks are at least two cycles apart, and a constant step of s gives a tick every N/s cycles.
- R7: A feedback pulse is produced on every (d+1)-th rising edge of `dco_clk`, where d is the value of `fb_div` (ratios 1 to 4).
- R8: Each cycle with |`phase_err`| < `lock_thresh` increments a qualification count. Any other cycle clears the count. `locked` is registered from (error below threshold) AND (count > `lock_time`), so any excursion drops it on the next edge.
- R9: Synchronous reset clears the counters, the integral, the accumulator, the lock count and `dco_clk`. During reset, `phase_err` = 0, `filt_word` = NOM, `dco_tick` = 0 and `locked` = 0. `locked` cannot rise before the (`lock_time`+2)-th edge after reset.
- R10: The reference passes through two synchroniser flops. Its rising-edge pulse, one cycle wide, comes from comparing the second flop with a third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Asynchronous reference signal |
| pd_bang | input | 1 | 1 selects the sign detector, 0 the counting detector |
| fb_div | input | 2 | Feedback ratio minus one |
| kp | input | 8 | Proportional gain, unsigned with FRAC fraction bits |
| ki | input | 8 | Integral gain, unsigned with FRAC fraction bits |
| lock_thresh | input | 12 | Error magnitude window for lock |
| lock_time | input | 16 | Qualification cycles for lock |
| dco_clk | output | 1 | Oscillator output level |
| dco_tick | output | 1 | One-cycle pulse on each oscillator toggle |
| phase_err | output | 12 | Signed registered phase error |
| filt_word | output | 6 | Clamped oscillator step |
| locked | output | 1 | Lock indication |

## Verification
The detector is first driven with the reference held low until its counter saturates. The peaks of the error sawtooth then expose the divider ratio for each setting, and a single rising edge then shows that the counter clears. In sign mode, a reference much faster than the feedback and one much slower must give a steady +1 and a steady -1, which separates the two orderings. Large gains drive the step into each clamp, where the tick spacing of 2 or 64 cycles distinguishes the bounds. A run that holds the integral at its ceiling and then reverses the error separates saturation from wrap-around. A cycle-accurate filter model checks every `filt_word` against the error seen one cycle earlier.

// File: rtl/adpll_pkg.sv
package adpll_pkg;

  typedef enum logic {
    PD_COUNT = 1'b0,
    PD_BANG  = 1'b1
  } pd_mode_e;

  typedef struct packed {
    logic fb_edge;
    logic ref_edge;
  } edge_pair_t;

endpackage

// File: rtl/adpll_ref_cond.sv
module adpll_ref_cond (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_edge
);

  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[1:0], ref_in};
  end

  assign ref_edge = sh_q[1] & ~sh_q[2];

  p_edge_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ref_edge |=> !ref_edge);

endmodule

// File: rtl/adpll_phase_det.sv
module adpll_phase_det
  import adpll_pkg::*;
#(
  parameter int EW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pd_mode_e             mode,
  input  edge_pair_t           edges,
  output logic signed [EW-1:0] err_q
);

  localparam int CW = EW - 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [1:0]         hit;
  logic [1:0][CW-1:0] cnt;

  assign hit = {edges.fb_edge, edges.ref_edge};

  // index 0 counts from reference edges, index 1 from feedback edges
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    logic [CW-1:0] c_q;
    always_ff @(posedge clk) begin
      if (rst)              c_q <= '0;
      else if (hit[g])      c_q <= '0;
      else if (c_q != CMAX) c_q <= c_q + 1'b1;
    end
    assign cnt[g] = c_q;

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (c_q == CMAX && !hit[g]) |=> c_q == CMAX);
  end

  logic              ref_pend, fb_pend;
  logic signed [1:0] bb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pend <= 1'b0;
      fb_pend  <= 1'b0;
      bb_q     <= 2'sd0;
    end else begin
      case (hit)
        2'b11: begin
          if (ref_pend)     bb_q <= 2'sd1;
          else if (fb_pend) bb_q <= -2'sd1;
          else              bb_q <= 2'sd0;
        end
        2'b01: begin
          if (fb_pend) begin
            bb_q    <= -2'sd1;
            fb_pend <= 1'b0;
          end else begin
            ref_pend <= 1'b1;
          end
        end
        2'b10: begin
          if (ref_pend) begin
            bb_q     <= 2'sd1;
            ref_pend <= 1'b0;
          end else begin
            fb_pend <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  logic signed [EW-1:0] cnt_diff, bb_ext, raw;

  assign cnt_diff = $signed({1'b0, cnt[0]}) - $signed({1'b0, cnt[1]});
  assign bb_ext   = {{(EW-2){bb_q[1]}}, bb_q};
  assign raw      = (mode == PD_BANG) ? bb_ext : cnt_diff;

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= raw;
  end

  p_bb_levels_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == PD_BANG) |-> (err_q == 1 || err_q == 0 || err_q == -1));

  p_no_dual_pend_r1: assert property (@(posedge clk) disable iff (rst)
    !(ref_pend && fb_pend));

endmodule

// File: rtl/adpll_loop_filter.sv
module adpll_loop_filter #(
  parameter int EW   = 12,
  parameter int GW   = 8,
  parameter int FRAC = 4,
  parameter int IW   = 20,
  parameter int N    = 64,
  parameter int NOM  = 8,
  parameter int OW   = $clog2(N/2) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  output logic [OW-1:0]        inc_q
);

  localparam int PW = EW + GW + 1;
  localparam int SW = ((PW > IW) ? PW : IW) + 2;
  localparam logic signed [SW-1:0] IMAX_S = (SW'(1) <<< (IW-1)) - SW'(1);
  localparam logic signed [SW-1:0] IMIN_S = -IMAX_S - SW'(1);
  localparam logic signed [SW-1:0] HI_S   = SW'(N/2);
  localparam logic signed [SW-1:0] LO_S   = SW'(1);
  localparam logic signed [SW-1:0] NOM_S  = SW'(NOM);
  localparam logic [OW-1:0]        NOM_O  = OW'(NOM);

  logic signed [PW-1:0] p_prod, i_prod, p_term, i_term;
  logic signed [IW-1:0] integ_q, integ_nx;
  logic signed [SW-1:0] i_sum, total;
  logic [OW-1:0]        inc_nx;

  assign p_prod = $signed({1'b0, kp}) * err;
  assign i_prod = $signed({1'b0, ki}) * err;
  assign p_term = p_prod >>> FRAC;
  assign i_term = i_prod >>> FRAC;

  assign i_sum = SW'(integ_q) + SW'(i_term);

  always_comb begin
    if (i_sum > IMAX_S)      integ_nx = IMAX_S[IW-1:0];
    else if (i_sum < IMIN_S) integ_nx = IMIN_S[IW-1:0];
    else                     integ_nx = i_sum[IW-1:0];
  end

  assign total = NOM_S + SW'(p_term) + SW'(integ_q);

  always_comb begin
    if (total < LO_S)      inc_nx = LO_S[OW-1:0];
    else if (total > HI_S) inc_nx = HI_S[OW-1:0];
    else                   inc_nx = total[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      inc_q   <= NOM_O;
    end else begin
      integ_q <= integ_nx;
      inc_q   <= inc_nx;
    end
  end

  p_integ_ceiling_r4: assert property (@(posedge clk) disable iff (rst)
    (integ_q == IMAX_S[IW-1:0] && !i_term[PW-1]) |=> integ_q == IMAX_S[IW-1:0]);

  p_integ_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (integ_q == IMIN_S[IW-1:0] && i_term[PW-1]) |=> integ_q == IMIN_S[IW-1:0]);

endmodule

// File: rtl/adpll_dco.sv
module adpll_dco #(
  parameter int N  = 64,
  parameter int OW = $clog2(N/2) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] inc,
  output logic          dco_clk,
  output logic          tick
);

  localparam int AW = $clog2(N) + 1;
  localparam logic [AW-1:0] MOD = AW'(N);

  logic [AW-1:0] acc_q, nxt;

  assign nxt = acc_q + AW'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      dco_clk <= 1'b0;
      tick    <= 1'b0;
    end else if (nxt >= MOD) begin
      acc_q   <= nxt - MOD;
      dco_clk <= ~dco_clk;
      tick    <= 1'b1;
    end else begin
      acc_q   <= nxt;
      tick    <= 1'b0;
    end
  end

  p_inc_bounds_r5: assert property (@(posedge clk) disable iff (rst)
    (inc >= OW'(1)) && (inc <= OW'(N/2)));

  p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_acc_below_mod_r6: assert property (@(posedge clk) disable iff (rst)
    acc_q < MOD);

endmodule

// File: rtl/adpll_fb_div.sv
module adpll_fb_div #(
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dco_rise,
  input  logic [DIVW-1:0] ratio_m1,
  output logic            fb_edge
);

  logic [DIVW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fb_edge <= 1'b0;
    end else begin
      fb_edge <= 1'b0;
      if (dco_rise) begin
        if (cnt_q >= ratio_m1) begin
          cnt_q   <= '0;
          fb_edge <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_fb_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    fb_edge |=> !fb_edge);

  p_fb_needs_rise_r7: assert property (@(posedge clk) disable iff (rst)
    fb_edge |-> $past(dco_rise));

endmodule

// File: rtl/adpll_lock_det.sv
module adpll_lock_det #(
  parameter int EW = 12,
  parameter int LW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err,
  input  logic [EW-1:0]        thresh,
  input  logic [LW-1:0]        ltime,
  output logic                 locked
);

  logic [EW-1:0] mag;
  logic          below;
  logic [LW-1:0] qual_q;

  assign mag   = err[EW-1] ? EW'(-err) : EW'(err);
  assign below = mag < thresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= '0;
      locked <= 1'b0;
    end else begin
      if (!below)           qual_q <= '0;
      else if (qual_q != '1) qual_q <= qual_q + 1'b1;
      locked <= below && (qual_q > ltime);
    end
  end

  // cycles since reset, used only by the checks below
  logic [LW:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)              since_q <= '0;
    else if (since_q != '1) since_q <= since_q + 1'b1;
  end

  p_lock_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (since_q <= {1'b0, ltime}) |-> !locked);

  p_lock_window_r8: assert property (@(posedge clk) disable iff (rst)
    locked |-> $past(below));

endmodule

// File: rtl/adpll_core.sv
module adpll_core
  import adpll_pkg::*;
#(
  parameter int EW   = 12,
  parameter int GW   = 8,
  parameter int FRAC = 4,
  parameter int IW   = 20,
  parameter int N    = 64,
  parameter int NOM  = 8,
  parameter int DIVW = 2,
  parameter int LW   = 16,
  localparam int OW  = $clog2(N/2) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_in,
  input  logic                 pd_bang,
  input  logic [DIVW-1:0]      fb_div,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [EW-1:0]        lock_thresh,
  input  logic [LW-1:0]        lock_time,
  output logic                 dco_clk,
  output logic                 dco_tick,
  output logic signed [EW-1:0] phase_err,
  output logic [OW-1:0]        filt_word,
  output logic                 locked
);

  edge_pair_t edges;
  pd_mode_e   mode;
  logic       ref_edge, fb_edge, dco_rise;

  assign mode     = pd_mode_e'(pd_bang);
  assign edges    = '{fb_edge: fb_edge, ref_edge: ref_edge};
  assign dco_rise = dco_tick & dco_clk;

  adpll_ref_cond u_ref (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (ref_in),
    .ref_edge (ref_edge)
  );

  adpll_phase_det #(.EW(EW)) u_pd (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .edges (edges),
    .err_q (phase_err)
  );

  adpll_loop_filter #(
    .EW(EW), .GW(GW), .FRAC(FRAC), .IW(IW), .N(N), .NOM(NOM), .OW(OW)
  ) u_lf (
    .clk   (clk),
    .rst   (rst),
    .err   (phase_err),
    .kp    (kp),
    .ki    (ki),
    .inc_q (filt_word)
  );

  adpll_dco #(.N(N), .OW(OW)) u_dco (
    .clk     (clk),
    .rst     (rst),
    .inc     (filt_word),
    .dco_clk (dco_clk),
    .tick    (dco_tick)
  );

  adpll_fb_div #(.DIVW(DIVW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .dco_rise (dco_rise),
    .ratio_m1 (fb_div),
    .fb_edge  (fb_edge)
  );

  adpll_lock_det #(.EW(EW), .LW(LW)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .err    (phase_err),
    .thresh (lock_thresh),
    .ltime  (lock_time),
    .locked (locked)
  );

endmodule

// File: tb/test_adpll_core.sv
`timescale 1ns/1ps
module test_adpll_core;

  localparam int  FRAC = 4;
  localparam int  N    = 64;
  localparam int  NOM  = 8;
  localparam longint IMAX = (64'sd1 <<< 19) - 1;
  localparam longint IMIN = -(64'sd1 <<< 19);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ref_in = 1'b0;
  logic              pd_bang = 1'b0;
  logic [1:0]        fb_div = 2'd0;
  logic [7:0]        kp = 8'd0;
  logic [7:0]        ki = 8'd0;
  logic [11:0]       lock_thresh = 12'd2;
  logic [15:0]       lock_time = 16'd20;
  logic              dco_clk, dco_tick, locked;
  logic signed [11:0] phase_err;
  logic [5:0]        filt_word;

  always #2.5 clk = ~clk;

  adpll_core i_adpll_core (
    .clk(clk), .rst(rst), .ref_in(ref_in), .pd_bang(pd_bang), .fb_div(fb_div),
    .kp(kp), .ki(ki), .lock_thresh(lock_thresh), .lock_time(lock_time),
    .dco_clk(dco_clk), .dco_tick(dco_tick), .phase_err(phase_err),
    .filt_word(filt_word), .locked(locked)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // reference generator
  bit ref_run = 0;
  bit ref_level = 0;
  int ref_per = 6;
  int ref_ph = 0;
  initial forever begin
    @(negedge clk);
    if (ref_run) begin
      ref_ph = (ref_ph + 1 >= ref_per) ? 0 : ref_ph + 1;
      ref_in = (ref_ph < ref_per / 2);
    end else begin
      ref_in = ref_level;
    end
  end

  // monitor and scoreboard
  longint pe_q[$];
  longint model_i = 0;
  longint cyc = 0, rel_cyc = 0, first_lock = -1;
  longint last_tick = -1, tick_iv = 0, last_peak = -1, peak_iv = 0, pe_max = 0;
  bit     prev_clk = 0;
  bit     win_on = 0;
  longint win_val = 0;
  int     win_bad = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst) begin
      model_i = 0;
      pe_q.delete();
      pe_q.push_back(0);
      rel_cyc = 0;
      first_lock = -1;
      last_tick = -1;
    end else begin
      longint e, pt, it, tot, ex;
      rel_cyc++;
      if (locked && first_lock < 0) first_lock = rel_cyc;
      if (pe_q.size() > 0) begin
        e   = pe_q.pop_front();
        pt  = (longint'(kp) * e) >>> FRAC;
        it  = (longint'(ki) * e) >>> FRAC;
        tot = NOM + pt + model_i;
        ex  = (tot < 1) ? 1 : ((tot > N/2) ? N/2 : tot);
        check(longint'(filt_word) == ex, "R3 filter step", filt_word, ex);
        model_i = model_i + it;
        if (model_i > IMAX) model_i = IMAX;
        if (model_i < IMIN) model_i = IMIN;
      end
      pe_q.push_back(longint'(phase_err));
      if (dco_tick) begin
        if (last_tick >= 0) tick_iv = cyc - last_tick;
        last_tick = cyc;
        check(dco_clk != prev_clk, "R6 toggle on tick", dco_clk, !prev_clk);
      end
      if (phase_err > pe_max) pe_max = phase_err;
      if (phase_err == 12'sd2047) begin
        if (last_peak >= 0) peak_iv = cyc - last_peak;
        last_peak = cyc;
      end
      if (win_on && longint'(phase_err) != win_val) win_bad++;
    end
    prev_clk = dco_clk;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    cycles(3);
    // R9 reset state
    check(phase_err == 0, "R9 phase_err in reset", phase_err, 0);
    check(filt_word == NOM, "R9 filt_word in reset", filt_word, NOM);
    check(dco_clk == 0, "R9 dco_clk in reset", dco_clk, 0);
    check(dco_tick == 0, "R9 dco_tick in reset", dco_tick, 0);
    check(locked == 0, "R9 locked in reset", locked, 0);
    rst = 1'b0;

    // R6 nominal step, counting mode, reference idle low
    cycles(60);
    check(tick_iv == N/NOM, "R6 nominal tick spacing", tick_iv, N/NOM);

    // R2 / R7 reference counter saturates, feedback sawtooth peaks
    cycles(2100);
    for (int d = 0; d < 4; d++) begin
      fb_div = 2'(d);
      cycles(200);
      check(peak_iv == 16*(d+1), "R7 feedback ratio", peak_iv, 16*(d+1));
    end
    check(pe_max == 2047, "R2 counter saturation peak", pe_max, 2047);

    // R2 / R10 a single reference rise clears its counter
    check(phase_err > 1900, "R2 error before reference edge", phase_err, 1900);
    ref_level = 1'b1;
    cycles(20);
    check(phase_err < 64 && phase_err > -64, "R10 counter cleared by synchronised edge", phase_err, 0);
    ref_level = 1'b0;

    // R5 upper clamp with large gains
    kp = 8'd255; ki = 8'd255;
    cycles(300);
    check(filt_word == N/2, "R5 upper clamp", filt_word, N/2);
    check(tick_iv == 2, "R6 fastest tick spacing", tick_iv, 2);

    // R4 saturated integral survives a reversed error
    pd_bang = 1'b1; ref_per = 300; ref_run = 1'b1; kp = 8'd0; ki = 8'd16;
    cycles(200);
    check(filt_word == N/2, "R4 integral held at ceiling", filt_word, N/2);

    // R1 / R8 / R9 fast reference in sign mode after a reset
    rst = 1'b1; kp = 8'd0; ki = 8'd0; fb_div = 2'd0; ref_per = 6;
    lock_thresh = 12'd2; lock_time = 16'd20;
    cycles(3);
    rst = 1'b0;
    cycles(100);
    win_val = 1; win_bad = 0; win_on = 1'b1;
    cycles(200);
    win_on = 1'b0;
    check(win_bad == 0, "R1 reference leads gives +1", win_bad, 0);
    check(first_lock == 22, "R9 earliest lock after reset", first_lock, 22);
    check(locked == 1, "R8 locked inside window", locked, 1);
    lock_thresh = 12'd1;
    cycles(3);
    check(locked == 0, "R8 excursion clears lock", locked, 0);
    lock_thresh = 12'd2;

    // R1 slow reference gives -1
    ref_per = 100;
    cycles(150);
    win_val = -1; win_bad = 0; win_on = 1'b1;
    cycles(300);
    win_on = 1'b0;
    check(win_bad == 0, "R1 reference lags gives -1", win_bad, 0);

    // R5 lower clamp
    kp = 8'd255; ref_per = 300;
    cycles(800);
    check(filt_word == 1, "R5 lower clamp", filt_word, 1);
    check(tick_iv == N, "R6 slowest tick spacing", tick_iv, N);

    summary();
    $finish;
  end

endmodule